// File: doc/BRIEF.md
# Transposed Carry-Save FIR Filter

This block is a synchronous finite impulse response filter for unsigned 8-bit samples. It has a fixed set of L constant 8-bit coefficients, so it is linear and time-invariant. Each accepted sample is sent to all tap multipliers in the same cycle. Each multiplier is an 8x8 unit built by splitting the operands in half, level by level, down to 2x2 cells.

The partial results move down a transposed chain of registers and are never resolved while they travel. Each stage stores a sum vector and a carry vector, and a 3:2 compressor adds the new tap product into the pair. A single carry-propagate adder at tap 0 turns the pair into the final value, which is then registered. The chain advances only on cycles where a sample is presented. A synchronous reset empties the filter history.

Top module: `fir_transposed_cs`

## Requirements
- R1: Let x[n] be the n-th sample accepted since reset. Each result is y[n] = sum over k = 0..L-1 of f[k]*x[n-k], with x[m] = 0 for m < 0. Coefficient f[k] sits in bits [8k+7:8k] of the coefficient parameter.
- R2: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high. The result for a sample is on `out_y` in the cycle after that sample is presented.
- R3: `out_y` is 16 + ceil(log2 L) bits wide, 19 bits by default. A run of 255-valued samples gives the exact full-precision sum with no wrap.
- R4: A cycle with `in_valid` low leaves the chain and `out_y` unchanged. Idle cycles between samples therefore insert no zero samples into the history.
- R5: A cycle with `rst` high clears every chain register, drives `out_y` to 0 and `out_valid` to 0 in the next cycle. Samples that arrive later see an empty history.
- R6: A single sample of value 1 followed by zeros produces f[0], f[1], …, f[L-1], and then zeros.
- R7: Every tap multiplier output equals the exact unsigned 16-bit product of the current sample and that tap's coefficient.
- R8: A run of constant samples of value v produces v*(f[0]+…+f[k]) as its k-th result, and holds at v*sum(f) once the run is L samples long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The sample on `in_sample` is accepted this cycle |
| in_sample | input | 8 | Unsigned input sample |
| out_valid | output | 1 | `out_y` holds a new result this cycle |
| out_y | output | 16+ceil(log2 L) | Filter result, unsigned |

## Verification
A corrupt sum or carry bit in stage k of the chain does not show up when it happens. It reaches `out_y` only after k more accepted samples, as a result that differs from the convolution, and it keeps its damage through every later stage. A chain that moves on an idle cycle shifts all later results by one sample, so the mismatch appears at the next accepted sample. A wrong multiplier cell corrupts the very next result for any sample that exercises that cell.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int SAMPLE_W = 8;
  localparam int COEF_W   = 8;
  localparam int PROD_W   = SAMPLE_W + COEF_W;

  // 2x2 unsigned product from gates: the leaf cell of the split multiplier
  function automatic logic [3:0] mul2x2(input logic [1:0] a, input logic [1:0] b);
    logic t01, t10, t11, c1;
    t01 = a[0] & b[1];
    t10 = a[1] & b[0];
    t11 = a[1] & b[1];
    c1  = t01 & t10;
    return {t11 & c1, t11 ^ c1, t01 ^ t10, a[0] & b[0]};
  endfunction

  // Width of a result that cannot wrap for a given number of taps
  function automatic int acc_width(input int taps);
    return PROD_W + $clog2(taps);
  endfunction
endpackage

// File: rtl/vedic_mul.sv
module vedic_mul #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int H = N / 2;

  if (N == 2) begin : g_cell
    assign p = fir_pkg::mul2x2(a, b);
  end else begin : g_split
    logic [N-1:0] ll, lh, hl, hh;
    logic [N:0]   mid;
    vedic_mul #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
    vedic_mul #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(lh));
    vedic_mul #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(hl));
    vedic_mul #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(hh));
    // cross terms carry weight 2^H; {hh,ll} is hh*2^N + ll
    assign mid = {1'b0, lh} + {1'b0, hl};
    assign p   = {hh, ll} + {{(H-1){1'b0}}, mid, {H{1'b0}}};
  end
endmodule

// File: rtl/csa3.sv
module csa3 #(
  parameter int W = 19
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] maj;
  assign sum   = x ^ y ^ z;
  assign maj   = (x & y) | (x & z) | (y & z);
  // carry out of the top bit is dropped: totals are taken modulo 2^W
  assign carry = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/fir_tap.sv
module fir_tap #(
  parameter int          W    = 19,
  parameter logic [7:0]  COEF = 8'd1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [7:0]   x,
  input  logic [W-1:0] up_s,
  input  logic [W-1:0] up_c,
  output logic [W-1:0] dn_s,
  output logic [W-1:0] dn_c
);
  logic [15:0]  prod;
  logic [W-1:0] nxt_s, nxt_c;

  vedic_mul #(.N(8)) u_mul (.a(x), .b(COEF), .p(prod));

  csa3 #(.W(W)) u_csa (
    .x({{(W-16){1'b0}}, prod}), .y(up_s), .z(up_c),
    .sum(nxt_s), .carry(nxt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_s <= '0;
      dn_c <= '0;
    end else if (en) begin
      dn_s <= nxt_s;
      dn_c <= nxt_c;
    end
  end

  assert_tap_product_R7: assert property (@(posedge clk) disable iff (rst)
    prod == ({8'd0, x} * {8'd0, COEF}));

  assert_chain_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dn_s) && $stable(dn_c)));
endmodule

// File: rtl/fir_transposed_cs.sv
module fir_transposed_cs #(
  parameter int             TAPS  = 8,
  parameter logic [TAPS*8-1:0] COEFS = 64'h01_04_0A_14_14_0A_04_01,
  localparam int            YW    = fir_pkg::acc_width(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_sample,
  output logic          out_valid,
  output logic [YW-1:0] out_y
);
  // chain_s/chain_c[k] is the carry-save partial held after tap k; index TAPS is empty
  logic [YW-1:0] chain_s [1:TAPS];
  logic [YW-1:0] chain_c [1:TAPS];

  assign chain_s[TAPS] = '0;
  assign chain_c[TAPS] = '0;

  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    fir_tap #(.W(YW), .COEF(COEFS[8*k +: 8])) u_tap (
      .clk(clk), .rst(rst), .en(in_valid), .x(in_sample),
      .up_s(chain_s[k+1]), .up_c(chain_c[k+1]),
      .dn_s(chain_s[k]),   .dn_c(chain_c[k])
    );
  end

  // tap 0: product, final compression and the one carry-propagate add
  logic [15:0]   head_prod;
  logic [YW-1:0] head_s, head_c, head_sum;

  vedic_mul #(.N(8)) u_head_mul (.a(in_sample), .b(COEFS[7:0]), .p(head_prod));

  csa3 #(.W(YW)) u_head_csa (
    .x({{(YW-16){1'b0}}, head_prod}), .y(chain_s[1]), .z(chain_c[1]),
    .sum(head_s), .carry(head_c)
  );

  assign head_sum = head_s + head_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_y <= head_sum;
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_y));

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |=> (!out_valid && out_y == '0));

  assert_head_product_R7: assert property (@(posedge clk) disable iff (rst)
    head_prod == ({8'd0, in_sample} * {8'd0, COEFS[7:0]}));
endmodule

// File: tb/fir_transposed_cs_tb.sv
module fir_transposed_cs_tb;
  localparam int TAPS = 8;
  localparam int YW   = 16 + $clog2(TAPS);
  localparam logic [TAPS*8-1:0] CF = {8'd255, 8'd1, 8'd128, 8'd7, 8'd64, 8'd200, 8'd3, 8'd17};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_sample = '0;
  logic out_valid;
  logic [YW-1:0] out_y;

  always #2 clk = ~clk;

  fir_transposed_cs #(.TAPS(TAPS), .COEFS(CF)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_y(out_y)
  );

  int tests = 0;
  int fails = 0;
  int hist [TAPS];
  logic [YW-1:0] exp_q [$];
  string tag_q [$];
  logic [YW-1:0] last_y = '0;
  bit done = 0;

  function automatic int coef(input int k);
    return int'(CF[8*k +: 8]);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
  endtask

  // driver: presents one sample and queues the convolution result
  task automatic send(input int v, input string req);
    longint acc = 0;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = v[7:0];
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    for (int k = 0; k < TAPS; k++) acc += longint'(coef(k)) * hist[k];
    exp_q.push_back(acc[YW-1:0]);
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sample = 8'hA5;
    end
  endtask

  // monitor: pops one expected value per valid result, checks hold while idle
  always @(negedge clk) begin
    if (rst) begin
      last_y = '0;
    end else if (out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected out_valid", 1, 0);
      end else begin
        string t;
        logic [YW-1:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_y, e);
      end
      last_y = out_y;
    end else begin
      check("R4 hold while idle", out_y, last_y);
    end
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    check("R5 reset out_valid", out_valid, 0);
    check("R5 reset out_y", out_y, 0);
    rst = 1'b0;

    // R6 impulse: coefficients come out in order, then zeros
    send(1, "R6 impulse");
    for (int i = 0; i < TAPS + 2; i++) send(0, "R6 impulse");
    idle(2);

    // R8 / R3 step of full-scale samples; final value exceeds 16 bits
    for (int i = 0; i < TAPS + 3; i++) send(255, "R8 R3 step");
    idle(1);
    check("R3 full-scale value", out_y, 255 * 675);

    // R1 / R4 random stream with idle gaps
    for (int i = 0; i < 200; i++) begin
      send($urandom_range(0, 255), "R1 R4 random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(2);

    // R5 reset mid stream clears history
    for (int i = 0; i < 4; i++) send(200 + i, "R1 pre-reset");
    idle(1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R5 mid-stream clear out_y", out_y, 0);
    check("R5 mid-stream clear out_valid", out_valid, 0);
    rst = 1'b0;
    clear_hist();
    send(2, "R5 history empty");
    for (int i = 0; i < TAPS; i++) send(0, "R5 history empty");
    idle(3);
    check("R2 all results delivered", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule